// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block makes the receive-side acceptance decision for an Ethernet frame from its 48-bit destination address. The six address bytes arrive one per `byte_vld` cycle, in the order they come off the wire. A `sof` strobe restarts the collection. While the bytes arrive, the block runs three checks in parallel:

- a compare against the programmed station address;
- a test for the all-ones broadcast address;
- a byte-wide CRC-32 accumulation over the address.

For a group (multicast) address, the top bits of that CRC select one bit of a 64-bit hash table. The set bit stands for "accept this group". Software loads the table as four 16-bit words.

The decision is produced once per frame as a single-cycle `verdict_vld` pulse, with `verdict_accept` carrying the result. Three controls shape the decision:

- a promiscuous control accepts everything;
- a broadcast-block control refuses the broadcast address;
- a station-block control refuses frames addressed to the station's own address.

Frame storage and checksum validation of the frame belong to other blocks.

Top module: `mcast_addr_filter`

## Requirements
- R1: While `rst_n` is low and after its release with no bytes presented, `verdict_vld` and `verdict_accept` are 0.
- R2: Byte collection and verdict timing:
  - A cycle with `sof`=1 restarts collection. A byte presented with `byte_vld`=1 in that same cycle is address byte 0.
  - Byte k of the address is `byte_data` on the k-th accepted `byte_vld` cycle. Idle cycles between bytes are allowed.
  - `verdict_vld` is 1 for exactly one cycle: the cycle after the one that presented byte 5.
  - Bytes beyond the sixth produce no further verdict until the next `sof`.
  - `verdict_accept` is 0 whenever `verdict_vld` is 0.
- R3: An address whose byte k equals `station_addr[8k+7:8k]` for every k is accepted when `phys_block`=0. With `phys_block`=1 the station-address match contributes nothing.
- R4: The all-ones address is accepted when `bcast_block`=0 and refused by the broadcast path when `bcast_block`=1. It never consults the hash table.
- R5: An address is a group address when bit 0 of byte 0 is 1 and it is not all-ones. For it the hash index is computed as follows, and the frame is accepted when `filter_bits[index]` is 1:
  - a reflected CRC-32 (polynomial 0xEDB88320, preset all ones, no final inversion) runs over bytes 0..5, each byte least significant bit first;
  - the index is bits 31:26 of the result.
- R6: With `filter_bits` all zero, no group address other than the station address is accepted unless `promisc_en`=1.
- R7: With `promisc_en`=1 every frame is accepted, whatever `bcast_block`, `phys_block`, `filter_bits` and the address are.
- R8: An individual address (bit 0 of byte 0 is 0) that differs from the station address is refused when `promisc_en`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Start-of-frame strobe, restarts address collection |
| byte_vld | input | 1 | `byte_data` holds a destination address byte |
| byte_data | input | 8 | Address byte, receive order |
| station_addr | input | 48 | Station address, byte k in bits 8k+7:8k |
| filter_bits | input | 64 | Hash table; word j (16 bits) in bits 16j+15:16j |
| promisc_en | input | 1 | Accept every frame |
| bcast_block | input | 1 | Refuse the all-ones address |
| phys_block | input | 1 | Ignore a station-address match |
| verdict_vld | output | 1 | One-cycle pulse, decision available |
| verdict_accept | output | 1 | Decision: 1 accept, 0 reject |

## Verification
Every verdict is due in the cycle after the sixth address byte. The bench drives inputs on falling edges and reads `verdict_vld` and `verdict_accept` at the falling edge that directly follows the sixth byte. It reads them again one falling edge later to confirm the pulse has ended.

During idle gaps between bytes, after surplus bytes, and after an aborted partial frame, it samples at every falling edge that no verdict has appeared early. Expected decisions come from a bit-serial CRC and the acceptance rules evaluated in the bench, swept over 64 group addresses and all eight control combinations.

// File: rtl/afl_pkg.sv
package afl_pkg;

   localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
   localparam int          CRC_W         = 32;

   // fold one byte into a reflected CRC-32, least significant bit first
   function automatic logic [CRC_W-1:0] crc_fold_byte(input logic [CRC_W-1:0] c_in,
                                                      input logic [7:0]       d);
      logic [CRC_W-1:0] c;
      c = c_in;
      for (int i = 0; i < 8; i++) begin
         if (c[0] ^ d[i]) c = (c >> 1) ^ CRC_POLY_REFL;
         else             c = c >> 1;
      end
      return c;
   endfunction

endpackage

// File: rtl/afl_byte_track.sv
module afl_byte_track #(
   parameter int ADDR_BYTES = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sof,
   input  logic                    byte_vld,
   input  logic [7:0]              byte_data,
   input  logic [8*ADDR_BYTES-1:0] station_addr,
   output logic                    take,
   output logic                    first,
   output logic                    last,
   output logic                    phys_hit,
   output logic                    bcast_hit,
   output logic                    mcast_hit
);
   localparam int CNT_W = $clog2(ADDR_BYTES + 1);
   localparam logic [CNT_W-1:0] N_C    = CNT_W'(ADDR_BYTES);
   localparam logic [CNT_W-1:0] LAST_C = CNT_W'(ADDR_BYTES - 1);

   logic [CNT_W-1:0] cnt_q, idx, idx_c;
   logic [7:0]       st_b [ADDR_BYTES];
   logic             match_q, ones_q, grp_q;
   logic             match_nx, ones_nx, grp_nx;

   for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_lane
      assign st_b[k] = station_addr[8*k +: 8];
   end

   assign idx   = sof ? '0 : cnt_q;
   assign idx_c = (idx < N_C) ? idx : '0;
   assign take  = byte_vld & (sof | (cnt_q < N_C));
   assign first = take & (idx == '0);
   assign last  = take & (idx == LAST_C);

   assign match_nx = (first | match_q) & (byte_data == st_b[idx_c]);
   assign ones_nx  = (first | ones_q) & (&byte_data);
   assign grp_nx   = first ? byte_data[0] : grp_q;

   assign phys_hit  = match_nx;
   assign bcast_hit = ones_nx;
   assign mcast_hit = grp_nx & ~ones_nx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= N_C;
         match_q <= 1'b0;
         ones_q  <= 1'b0;
         grp_q   <= 1'b0;
      end else if (take) begin
         cnt_q   <= idx + CNT_W'(1);
         match_q <= match_nx;
         ones_q  <= ones_nx;
         grp_q   <= grp_nx;
      end else if (sof) begin
         cnt_q   <= '0;
      end
   end
endmodule

// File: rtl/afl_crc_accum.sv
module afl_crc_accum #(
   parameter int HASH_BITS = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 take,
   input  logic                 first,
   input  logic [7:0]           byte_data,
   output logic [HASH_BITS-1:0] hash_idx
);
   import afl_pkg::*;

   logic [CRC_W-1:0] crc_q, seed, crc_nx;

   assign seed     = first ? '1 : crc_q;
   assign crc_nx   = crc_fold_byte(seed, byte_data);
   assign hash_idx = crc_nx[CRC_W-1 -: HASH_BITS];

   always_ff @(posedge clk) begin
      if (!rst_n)    crc_q <= '1;
      else if (take) crc_q <= crc_nx;
   end
endmodule

// File: rtl/afl_hash_lookup.sv
module afl_hash_lookup #(
   parameter int HASH_BITS = 6,
   parameter int WORD_W    = 16
) (
   input  logic [(1<<HASH_BITS)-1:0] filter_bits,
   input  logic [HASH_BITS-1:0]      idx,
   output logic                      hit
);
   localparam int TABLE_W = 1 << HASH_BITS;
   localparam int NWORDS  = TABLE_W / WORD_W;
   localparam int LSB_W   = $clog2(WORD_W);
   localparam int WSEL_W  = HASH_BITS - LSB_W;

   if ((WORD_W < 2) || ((1 << LSB_W) != WORD_W) || (WORD_W > TABLE_W)) begin : g_bad_word
      $error("afl_hash_lookup: WORD_W must be a power of two between 2 and the table size");
   end

   if (NWORDS == 1) begin : g_flat
      assign hit = filter_bits[idx];
   end else begin : g_words
      logic [WORD_W-1:0] words [NWORDS];
      logic [WORD_W-1:0] word_sel;
      for (genvar j = 0; j < NWORDS; j++) begin : g_w
         assign words[j] = filter_bits[j*WORD_W +: WORD_W];
      end
      assign word_sel = words[idx[HASH_BITS-1 -: WSEL_W]];
      assign hit      = word_sel[idx[LSB_W-1:0]];
   end
endmodule

// File: rtl/mcast_addr_filter.sv
module mcast_addr_filter #(
   parameter int ADDR_BYTES    = 6,
   parameter int HASH_BITS     = 6,
   parameter int FILTER_WORD_W = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      sof,
   input  logic                      byte_vld,
   input  logic [7:0]                byte_data,
   input  logic [8*ADDR_BYTES-1:0]   station_addr,
   input  logic [(1<<HASH_BITS)-1:0] filter_bits,
   input  logic                      promisc_en,
   input  logic                      bcast_block,
   input  logic                      phys_block,
   output logic                      verdict_vld,
   output logic                      verdict_accept
);
   if (ADDR_BYTES < 2) begin : g_bad_bytes
      $error("mcast_addr_filter: ADDR_BYTES must be at least 2");
   end
   if ((HASH_BITS < 1) || (HASH_BITS > 12)) begin : g_bad_hash
      $error("mcast_addr_filter: HASH_BITS must lie in 1..12");
   end

   logic                 take, first, last;
   logic                 phys_hit, bcast_hit, mcast_hit;
   logic [HASH_BITS-1:0] hash_idx;
   logic                 hash_hit, accept_nx;

   afl_byte_track #(.ADDR_BYTES(ADDR_BYTES)) u_track (
      .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld),
      .byte_data(byte_data), .station_addr(station_addr),
      .take(take), .first(first), .last(last),
      .phys_hit(phys_hit), .bcast_hit(bcast_hit), .mcast_hit(mcast_hit)
   );

   afl_crc_accum #(.HASH_BITS(HASH_BITS)) u_crc (
      .clk(clk), .rst_n(rst_n), .take(take), .first(first),
      .byte_data(byte_data), .hash_idx(hash_idx)
   );

   afl_hash_lookup #(.HASH_BITS(HASH_BITS), .WORD_W(FILTER_WORD_W)) u_lookup (
      .filter_bits(filter_bits), .idx(hash_idx), .hit(hash_hit)
   );

   assign accept_nx = promisc_en
                    | (bcast_hit & ~bcast_block)
                    | (phys_hit  & ~phys_block)
                    | (mcast_hit & hash_hit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         verdict_vld    <= 1'b0;
         verdict_accept <= 1'b0;
      end else begin
         verdict_vld    <= last;
         verdict_accept <= last & accept_nx;
      end
   end
endmodule

// File: rtl/afl_checker.sv
module afl_checker #(
   parameter int HASH_BITS = 6
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      byte_vld,
   input logic [(1<<HASH_BITS)-1:0] filter_bits,
   input logic                      promisc_en,
   input logic                      bcast_block,
   input logic                      phys_block,
   input logic                      verdict_vld,
   input logic                      verdict_accept
);
   p_accept_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !verdict_vld |-> !verdict_accept);

   p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      verdict_vld |=> !verdict_vld);

   p_follows_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
      verdict_vld |-> $past(byte_vld));

   p_promisc_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (verdict_vld && $past(promisc_en)) |-> verdict_accept);

   p_empty_table_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (verdict_vld && $past(!promisc_en && bcast_block && phys_block && (filter_bits == '0)))
      |-> !verdict_accept);
endmodule

bind mcast_addr_filter afl_checker #(.HASH_BITS(HASH_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .filter_bits(filter_bits),
   .promisc_en(promisc_en), .bcast_block(bcast_block), .phys_block(phys_block),
   .verdict_vld(verdict_vld), .verdict_accept(verdict_accept)
);

// File: tb/mcast_addr_filter_tb.sv
`timescale 1ns/1ps
module mcast_addr_filter_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sof = 1'b0;
   logic        byte_vld = 1'b0;
   logic [7:0]  byte_data = '0;
   logic [47:0] station_addr = 48'h0A1B_2C3D_4E52;
   logic [63:0] filter_bits = '0;
   logic        promisc_en = 1'b0;
   logic        bcast_block = 1'b0;
   logic        phys_block = 1'b0;
   logic        verdict_vld, verdict_accept;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #10 clk = ~clk;

   mcast_addr_filter u_dut (
      .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld), .byte_data(byte_data),
      .station_addr(station_addr), .filter_bits(filter_bits), .promisc_en(promisc_en),
      .bcast_block(bcast_block), .phys_block(phys_block),
      .verdict_vld(verdict_vld), .verdict_accept(verdict_accept)
   );

   task automatic chk(input logic got, input logic exp, input string tag);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0b expected %0b", tag, got, exp);
      end
   endtask

   function automatic logic [5:0] ref_index(input logic [47:0] a);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 0; i < 48; i++)
         c = (c[0] ^ a[i]) ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
      return c[31:26];
   endfunction

   function automatic logic ref_accept(input logic [47:0] a);
      logic bc, ph, grp;
      bc  = (a == '1);
      ph  = (a == station_addr);
      grp = a[0] & ~bc;
      return promisc_en | (bc & ~bcast_block) | (ph & ~phys_block)
           | (grp & filter_bits[ref_index(a)]);
   endfunction

   // present six bytes with optional idle gaps; sample the verdict after the sixth
   task automatic frame(input logic [47:0] a, input int gap, input string tag);
      for (int k = 0; k < 6; k++) begin
         sof = (k == 0);
         byte_vld = 1'b1;
         byte_data = a[8*k +: 8];
         @(negedge clk);
         sof = 1'b0;
         byte_vld = 1'b0;
         if (k < 5) begin
            for (int g = 0; g < gap; g++) begin
               chk(verdict_vld, 1'b0, {tag, " R2 no early verdict"});
               @(negedge clk);
            end
            chk(verdict_vld, 1'b0, {tag, " R2 no early verdict"});
         end
      end
      chk(verdict_vld, 1'b1, {tag, " R2 verdict due"});
      chk(verdict_accept, ref_accept(a), tag);
      @(negedge clk);
      chk(verdict_vld, 1'b0, {tag, " R2 pulse ends"});
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [47:0] a;
      logic [47:0] kinds [4];
      repeat (3) @(negedge clk);
      chk(verdict_vld, 1'b0, "R1 vld in reset");
      chk(verdict_accept, 1'b0, "R1 accept in reset");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(verdict_vld, 1'b0, "R1 vld after reset");
      chk(verdict_accept, 1'b0, "R1 accept after reset");

      // R5: each group address against a one-hot table and its complement
      for (int k = 0; k < 64; k++) begin
         a = {8'(k), 8'h00, 8'h00, 8'h5E, 8'h00, 8'h01};
         filter_bits = 64'd1 << ref_index(a);
         frame(a, 0, "R5 hash bit set");
         chk(verdict_accept, 1'b0, "R2 accept low after pulse");
         filter_bits = ~(64'd1 << ref_index(a));
         frame(a, 0, "R5 hash bit clear");
      end

      // R6: empty table refuses group addresses
      filter_bits = '0;
      for (int k = 0; k < 16; k++) begin
         a = {8'(3*k), 8'h11, 8'h22, 8'h33, 8'h44, 8'h33};
         frame(a, 0, "R6 empty table");
      end

      // R3 R4 R7 R8: every control combination against each address kind
      kinds[0] = station_addr;
      kinds[1] = '1;
      kinds[2] = station_addr ^ 48'h0100_0000_0000;
      kinds[3] = 48'h0700_0000_5E01;
      filter_bits = '1;
      for (int cfg = 0; cfg < 8; cfg++) begin
         promisc_en  = cfg[0];
         bcast_block = cfg[1];
         phys_block  = cfg[2];
         frame(kinds[0], 0, "R3 station address");
         frame(kinds[1], 0, "R4 broadcast");
         frame(kinds[2], 0, "R8 other individual");
         frame(kinds[3], 0, "R7 group full table");
      end
      promisc_en = 1'b0; bcast_block = 1'b0; phys_block = 1'b0;

      // R4: broadcast ignores an empty hash table
      filter_bits = '0;
      frame('1, 0, "R4 broadcast empty table");
      chk(ref_accept('1), 1'b1, "R4 reference sanity");

      // R2: idle gaps between bytes
      frame(station_addr, 2, "R2 gapped station frame");

      // R2: surplus bytes give no second verdict
      for (int k = 0; k < 3; k++) begin
         byte_vld = 1'b1; byte_data = 8'hA5;
         @(negedge clk);
         chk(verdict_vld, 1'b0, "R2 surplus byte");
      end
      byte_vld = 1'b0;
      @(negedge clk);
      chk(verdict_vld, 1'b0, "R2 surplus byte");

      // R2: aborted partial frame, then restart with sof
      for (int k = 0; k < 3; k++) begin
         sof = (k == 0); byte_vld = 1'b1; byte_data = 8'hFF;
         @(negedge clk);
         chk(verdict_vld, 1'b0, "R2 partial frame");
      end
      sof = 1'b0; byte_vld = 1'b0;
      frame(station_addr, 0, "R2 restart station frame");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule